// File: doc/BRIEF.md
# Greedy Test Vector Reordering Engine

This block takes a set of test vectors, known only by their index, and picks the order in which to apply them so that the circuit under test switches less. Before a run, a load port fills two cost tables one entry per clock. The first table holds the switching activity caused by applying each vector on its own. The second is a directional square table that holds the activity caused by applying vector `c` right after vector `r`.

A start pulse, together with the number of vectors to order, begins a run. The engine first picks the vector with the cheapest stand-alone cost. After that it repeatedly picks the vector that is still unused and is cheapest to reach from the vector chosen last, reading the row of that last vector. Each minimum search scans the candidates one per clock and skips the vectors already placed, so each output index takes `count + 2` cycles. Every chosen index leaves the block with a one-cycle strobe. When the path is complete, the engine raises a done flag and presents the accumulated path cost.

Top module: `vec_order_engine`

## Requirements
- R1: After synchronous reset, `out_valid`, `done` and `busy` are 0 and `total` is 0.
- R2: The first index of a run is the vector in `0..count-1` with the smallest initial cost. On equal costs the lower index wins.
- R3: Each later index is the unused vector with the smallest cost in the row of the most recently emitted vector, on equal costs the lower index. The table is directional: entry (r,c) is the cost of c following r, and (c,r) is never consulted for that step.
- R4: A run emits exactly `count` indices, and each index in `0..count-1` appears exactly once.
- R5: `total` equals the initial cost of the first index plus the pairwise costs of every consecutive pair in the emitted order. It is wide enough for `NVEC` times the maximum cost plus one more maximum cost.
- R6: `out_valid` is high for one cycle per index. `done` rises in the cycle after the last index, `total` is final from then on, and both hold until the next accepted start.
- R7: `start` is ignored while `busy` is 1. It is also ignored when `vec_count` is 0 or greater than `NVEC`.
- R8: When `ld_en` is 1 and `busy` is 0, one entry is written per cycle. `ld_sel`=1 writes initial cost `ld_col`. `ld_sel`=0 writes pair entry (`ld_row`,`ld_col`). Writes while `busy` is 1 are ignored.
- R9: With `vec_count`=1 the single index 0 is emitted, and `total` equals its initial cost.
- R10: The first `out_valid` appears `count+2` clock edges after the edge that accepts `start`, and consecutive `out_valid` pulses are exactly `count+2` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one cost table entry this cycle |
| ld_sel | input | 1 | 1 selects the initial cost table, 0 the pair table |
| ld_row | input | IW | Source vector index for a pair table write |
| ld_col | input | IW | Destination index for a pair write, vector index for an initial write |
| ld_data | input | CW | Cost value to write |
| start | input | 1 | Start a run |
| vec_count | input | CNTW | Number of vectors in the run (1..NVEC) |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | One-cycle strobe for `out_idx` |
| out_idx | output | IW | Next vector index in the application order |
| done | output | 1 | The run is finished and `total` is final |
| total | output | TW | Accumulated switching activity of the path |

## Verification
A corrupted visited vector shows up at the ports within one output strobe: an index repeats, or an index is skipped, and the count of strobes no longer matches `vec_count`. A scanner that keeps the wrong minimum, or reads the wrong row, changes the very next emitted index and the final `total`. Broken tie handling shows up at the step where two candidates cost the same. Errors in the pipeline or the counter show up as `out_valid` spacing other than `count+2`, or as `done` arriving on the wrong cycle. The sweeps cover a reference six-vector table, all-equal ties, asymmetric tables, full-size tables with maximum costs, the single-vector case, and start or load requests made during a run.

// File: rtl/vec_order_pkg.sv
`timescale 1ns/1ps
package vec_order_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_EMIT,
    ST_FIN
  } ord_state_t;
endpackage

// File: rtl/cost_ram.sv
`timescale 1ns/1ps
module cost_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/min_scanner.sv
`timescale 1ns/1ps
module min_scanner #(
  parameter int IW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic [CW-1:0] in_cost,
  output logic          have,
  output logic [IW-1:0] best_idx,
  output logic [CW-1:0] best_cost
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      have      <= 1'b0;
      best_idx  <= '0;
      best_cost <= '0;
    end else if (in_valid && (!have || in_cost < best_cost)) begin
      have      <= 1'b1;
      best_idx  <= in_idx;
      best_cost <= in_cost;
    end
  end

  // R2 R3: a later candidate of equal cost never displaces the held one
  tie_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
    (have && in_valid && !clr && in_cost == best_cost) |=> (best_idx == $past(best_idx)));

  // R3: the held minimum never exceeds any candidate that was offered
  min_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (have && in_valid && !clr) |=> (best_cost <= $past(in_cost)));
endmodule

// File: rtl/vec_order_engine.sv
`timescale 1ns/1ps
module vec_order_engine
  import vec_order_pkg::*;
#(
  parameter int NVEC = 16,
  parameter int CW   = 8,
  localparam int IW   = $clog2(NVEC),
  localparam int CNTW = $clog2(NVEC + 1),
  localparam int TW   = CW + CNTW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [IW-1:0]   ld_row,
  input  logic [IW-1:0]   ld_col,
  input  logic [CW-1:0]   ld_data,
  input  logic            start,
  input  logic [CNTW-1:0] vec_count,
  output logic            busy,
  output logic            out_valid,
  output logic [IW-1:0]   out_idx,
  output logic            done,
  output logic [TW-1:0]   total
);
  ord_state_t      state;
  logic [CNTW-1:0] run_cnt;
  logic [CNTW-1:0] scan_j;
  logic [CNTW-1:0] picked;
  logic [NVEC-1:0] visited;
  logic [IW-1:0]   cur;
  logic            first;
  logic            pv;
  logic [IW-1:0]   pj;

  logic [CW-1:0]   init_rd, pair_rd, cand_cost;
  logic            have;
  logic [IW-1:0]   best_idx;
  logic [CW-1:0]   best_cost;

  logic accept, scan_rd, last_j, last_pick, we_init, we_pair;

  assign busy      = (state != ST_IDLE);
  assign accept    = start && !busy && (vec_count != '0) && (vec_count <= CNTW'(NVEC));
  assign scan_rd   = (state == ST_SCAN);
  assign last_j    = (scan_j == run_cnt - CNTW'(1));
  assign last_pick = ((picked + CNTW'(1)) == run_cnt);
  assign we_init   = ld_en && ld_sel && !busy;
  assign we_pair   = ld_en && !ld_sel && !busy;
  assign cand_cost = first ? init_rd : pair_rd;

  cost_ram #(.AW(IW), .DW(CW)) u_init_tab (
    .clk(clk), .we(we_init), .waddr(ld_col), .wdata(ld_data),
    .re(scan_rd && first), .raddr(scan_j[IW-1:0]), .rdata(init_rd)
  );

  cost_ram #(.AW(2*IW), .DW(CW)) u_pair_tab (
    .clk(clk), .we(we_pair), .waddr({ld_row, ld_col}), .wdata(ld_data),
    .re(scan_rd && !first), .raddr({cur, scan_j[IW-1:0]}), .rdata(pair_rd)
  );

  min_scanner #(.IW(IW), .CW(CW)) u_scan (
    .clk(clk), .rst(rst), .clr(accept || state == ST_EMIT),
    .in_valid(pv), .in_idx(pj), .in_cost(cand_cost),
    .have(have), .best_idx(best_idx), .best_cost(best_cost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= 1'b0;
      pj <= '0;
    end else begin
      pv <= scan_rd && !visited[scan_j[IW-1:0]];
      pj <= scan_j[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      run_cnt   <= '0;
      scan_j    <= '0;
      picked    <= '0;
      visited   <= '0;
      cur       <= '0;
      first     <= 1'b1;
      out_valid <= 1'b0;
      out_idx   <= '0;
      done      <= 1'b0;
      total     <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_SCAN;
          run_cnt <= vec_count;
          scan_j  <= '0;
          picked  <= '0;
          visited <= '0;
          first   <= 1'b1;
          done    <= 1'b0;
          total   <= '0;
        end
        ST_SCAN: begin
          scan_j <= scan_j + CNTW'(1);
          if (last_j) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_EMIT;
        ST_EMIT: begin
          out_valid         <= 1'b1;
          out_idx           <= best_idx;
          total             <= total + TW'(best_cost);
          visited[best_idx] <= 1'b1;
          cur               <= best_idx;
          first             <= 1'b0;
          picked            <= picked + CNTW'(1);
          scan_j            <= '0;
          state             <= last_pick ? ST_FIN : ST_SCAN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: reset leaves the outputs quiet
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !done && !busy && total == '0));

  // R4: a pick always has a candidate, and that candidate is still unused
  pick_unused_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT) |-> (have && !visited[best_idx]));

  // R4: one visited bit per emitted index
  visit_count_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(visited) == int'(picked)));

  // R6: the index strobe lasts a single cycle
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: done rises only right after the last index
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(out_valid) && picked == run_cnt));

  // R5: within a run the accumulated total never shrinks
  total_grows_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (total >= $past(total)));

  // R7: a run begins only from an idle engine with a start request
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && !$past(busy)));
endmodule

// File: tb/vec_order_engine_test.sv
`timescale 1ns/1ps
module vec_order_engine_test;
  localparam int NVEC = 16;
  localparam int CW   = 8;
  localparam int IW   = $clog2(NVEC);
  localparam int CNTW = $clog2(NVEC + 1);
  localparam int TW   = CW + CNTW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [IW-1:0]   ld_row = '0, ld_col = '0;
  logic [CW-1:0]   ld_data = '0;
  logic [CNTW-1:0] vec_count = '0;
  logic            busy, out_valid, done;
  logic [IW-1:0]   out_idx;
  logic [TW-1:0]   total;

  int checks = 0;
  int fails  = 0;
  int m_init [NVEC];
  int m_pair [NVEC][NVEC];
  int e_ord  [NVEC];
  int e_total;
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  vec_order_engine #(.NVEC(NVEC), .CW(CW)) uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .start(start), .vec_count(vec_count),
    .busy(busy), .out_valid(out_valid), .out_idx(out_idx), .done(done), .total(total)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextr();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed & 32'h7fff_ffff);
  endfunction

  task automatic put_init(input int i, input int v);
    ld_en = 1; ld_sel = 1; ld_col = IW'(i); ld_data = CW'(v);
    @(negedge clk);
    ld_en = 0;
    m_init[i] = v;
  endtask

  task automatic put_pair(input int r, input int c, input int v);
    ld_en = 1; ld_sel = 0; ld_row = IW'(r); ld_col = IW'(c); ld_data = CW'(v);
    @(negedge clk);
    ld_en = 0;
    m_pair[r][c] = v;
  endtask

  // greedy model built from R2, R3, R5
  task automatic model(input int cnt);
    bit used [NVEC];
    int b, last;
    for (int i = 0; i < NVEC; i++) used[i] = 0;
    b = 0;
    for (int i = 1; i < cnt; i++) if (m_init[i] < m_init[b]) b = i;
    e_ord[0] = b; used[b] = 1; e_total = m_init[b]; last = b;
    for (int k = 1; k < cnt; k++) begin
      b = -1;
      for (int i = 0; i < cnt; i++)
        if (!used[i] && (b < 0 || m_pair[last][i] < m_pair[last][b])) b = i;
      e_ord[k] = b; used[b] = 1; e_total += m_pair[last][b]; last = b;
    end
  endtask

  // disturb: 0 none, 1 extra start while busy, 2 load while busy
  task automatic run_case(input int cnt, input int disturb);
    int got [NVEC];
    int n, c, last_c;
    bit seen_done, timed_out;
    model(cnt);
    n = 0; c = 0; last_c = 0; seen_done = 0; timed_out = 0;
    vec_count = CNTW'(cnt); start = 1;
    while (!seen_done) begin
      @(negedge clk);
      c++;
      if (c == 1) start = 0;
      if (disturb == 1 && c == 4) begin start = 1; vec_count = CNTW'(1); end
      if (disturb == 1 && c == 5) start = 0;
      if (disturb == 2 && c == 4) begin
        ld_en = 1; ld_sel = 1; ld_col = IW'(e_ord[cnt-1]); ld_data = '0;
      end
      if (disturb == 2 && c == 5) ld_en = 0;
      if (out_valid) begin
        if (n < NVEC) got[n] = int'(out_idx);
        // R10: pulse timing
        if (n == 0) check(c == cnt + 3, "R10 first strobe", c, cnt + 3);
        else check(c - last_c == cnt + 2, "R10 strobe spacing", c - last_c, cnt + 2);
        last_c = c;
        n++;
      end
      if (done) begin
        seen_done = 1;
        // R6: done right after the last strobe
        check(c == last_c + 1, "R6 done timing", c, last_c + 1);
      end
      if (c > 4000) begin seen_done = 1; timed_out = 1; end
    end
    check(!timed_out, "R6 run finished", c, 0);
    // R4: count of indices
    check(n == cnt, "R4 index count", n, cnt);
    if (n > 0) check(got[0] == e_ord[0], "R2 first index", got[0], e_ord[0]);
    for (int k = 1; k < cnt && k < n; k++)
      check(got[k] == e_ord[k], "R3 path index", got[k], e_ord[k]);
    // R5: accumulated total
    check(int'(total) == e_total, "R5 total", int'(total), e_total);
    repeat (3) @(negedge clk);
    check(done && int'(total) == e_total && !busy, "R6 done held", int'(done), 1);
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      m_init[i] = 0;
      for (int j = 0; j < NVEC; j++) m_pair[i][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(!out_valid && !done && !busy && total == '0, "R1 reset outputs", int'(busy), 0);

    // R8: fill all entries with zero through the load port
    for (int i = 0; i < NVEC; i++) begin
      put_init(i, 0);
      for (int j = 0; j < NVEC; j++) put_pair(i, j, 0);
    end

    // six-vector table; expected order 2,5,4,0,1,3 with total 26 (R2, R3 tie at 7)
    begin
      int iv [6] = '{15, 22, 0, 18, 15, 12};
      int pm [6][6] = '{'{0, 7, 7, 7, 6, 7}, '{5, 0, 8, 4, 9, 8}, '{7, 14, 0, 10, 7, 4},
                        '{7, 4, 4, 0, 7, 8}, '{6, 7, 7, 7, 0, 5}, '{7, 10, 4, 12, 5, 0}};
      for (int i = 0; i < 6; i++) begin
        put_init(i, iv[i]);
        for (int j = 0; j < 6; j++) put_pair(i, j, pm[i][j]);
      end
    end
    run_case(6, 0);
    check(e_total == 26, "R5 six-vector total", e_total, 26);

    // R7: start during a run is ignored
    run_case(6, 1);
    // R8: a load during a run is ignored; a rerun still matches the old table
    run_case(6, 2);
    run_case(6, 0);

    // R7: invalid counts are ignored
    vec_count = '0; start = 1; @(negedge clk); start = 0; @(negedge clk);
    check(!busy && done, "R7 count zero ignored", int'(busy), 0);
    vec_count = CNTW'(17); start = 1; @(negedge clk); start = 0; @(negedge clk);
    check(!busy && done, "R7 count over max ignored", int'(busy), 0);

    // R3: directional table; the reverse entries are cheap but must not be used
    for (int i = 0; i < 4; i++) begin
      put_init(i, 10 + i);
      for (int j = 0; j < 4; j++) put_pair(i, j, (j > i) ? 50 - j : 1);
    end
    run_case(4, 0);

    // R2 R3: all costs equal, so the order is ascending
    for (int i = 0; i < NVEC; i++) begin
      put_init(i, 9);
      for (int j = 0; j < NVEC; j++) put_pair(i, j, 9);
    end
    run_case(NVEC, 0);

    // R5: full size with maximum costs
    for (int i = 0; i < NVEC; i++) begin
      put_init(i, 255);
      for (int j = 0; j < NVEC; j++) put_pair(i, j, 255);
    end
    run_case(NVEC, 0);

    // R9: a single vector
    put_init(0, 77);
    run_case(1, 0);
    check(e_ord[0] == 0 && e_total == 77, "R9 single vector", e_total, 77);

    // sweep over sizes with pseudo-random tables
    for (int s = 2; s <= NVEC; s++) begin
      for (int i = 0; i < s; i++) begin
        put_init(i, nextr() % 256);
        for (int j = 0; j < s; j++) put_pair(i, j, nextr() % 8);
      end
      run_case(s, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule